// File: doc/BRIEF.md
# Signature Row Read Window Controller

This block lets a processor fetch bytes from a small factory signature row in place of its program memory. Software arms the block with one write to an eight-bit control register, setting the store-enable bit and the signature-select bit together. The block then opens a short window. The first program-memory load that arrives during that window is served from the signature row instead of from flash. The byte returned depends on the load address.

The window is one-shot and expires on its own. It closes after the first load it serves. It also closes when three CPU cycles pass with no load. After it closes, loads see plain flash data again. The signature bytes and the calibration byte are parameters. The flash itself sits outside the block, and its read data passes through to the output whenever the window is closed.

Top module: `sig_row_rd_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `win_open_o` is 0 and `rd_data_o` equals `flash_rdata_i`.
- R2: A register write whose data has bit 0 (store enable) and bit 5 (signature select) both set to 1 raises `win_open_o` in the cycle after the write.
- R3: A register write with bit 0 or bit 5 clear leaves the window closed, and loads keep returning flash data.
- R4: A load inside the window returns a signature byte. Address 0x0000 gives byte 1, 0x0002 gives byte 2, 0x0004 gives byte 3, and 0x0001 gives the calibration byte. The byte appears on `rd_data_o` in the same cycle as the load strobe.
- R5: A load inside the window from any other address returns 0xFF.
- R6: A load inside the window closes it: `win_open_o` is 0 in the next cycle, and later loads return flash data.
- R7: With no load, the window is open in cycles 1, 2 and 3 after the arming write and closed from cycle 4 onward. A load in cycle 3 is still served from the signature row.
- R8: A non-arming register write while the window is open closes it from the next cycle.
- R9: Whenever the window is closed, `rd_data_o` equals `flash_rdata_i`, whether or not a load is requested.
- R10: An asynchronous reset during an open window closes it at once.
- R11: An arming write while the window is open restarts the three-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data (bit 0 store enable, bit 5 signature select) |
| ld_req_i | input | 1 | Program-memory load request |
| ld_addr_i | input | 16 | Byte address of the load |
| flash_rdata_i | input | 8 | Byte read from flash for the current load |
| rd_data_o | output | 8 | Load result returned to the CPU |
| win_open_o | output | 1 | High while the signature read window is open |

## Verification
Load data is combinational: `rd_data_o` is valid in the same cycle as `ld_req_i`. The window state is registered, so `win_open_o` changes one edge after an arming write, a served load or a disarming write. The bench drives every input on the falling edge. It samples `rd_data_o` 1 ns later within the same cycle, and it checks `win_open_o` after each falling edge. Cycle 1 of the window is therefore the first sample taken after the arming write is released. The timeout test counts the window cycles one by one, and the checker limits them with its own cycle counter.

// File: rtl/sig_row_pkg.sv
package sig_row_pkg;
  localparam int unsigned ROW_ENTRIES = 4;
  localparam int unsigned ROW_ADDR_W  = 16;
  // signature row map; entry order matches the packed value parameter
  localparam logic [ROW_ADDR_W-1:0] ROW_ADDR [ROW_ENTRIES] = '{
    16'h0000, 16'h0002, 16'h0004, 16'h0001
  };
  localparam logic [7:0] RSVD_BYTE = 8'hFF;
endpackage

// File: rtl/sig_row_win_ctl.sv
module sig_row_win_ctl #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned SIG_BIT    = 5,
  parameter int unsigned WIN_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ld_req_i,
  output logic              win_open_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);

  logic             arm_w;
  logic [CNT_W-1:0] age_q;
  logic             open_q;

  assign arm_w = reg_wdata_i[EN_BIT] & reg_wdata_i[SIG_BIT];

  // register writes take priority over window expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (reg_we_i) begin
      open_q <= arm_w;
      age_q  <= arm_w ? CNT_W'(1) : '0;
    end else if (open_q) begin
      if (ld_req_i || age_q == CNT_W'(WIN_CYCLES)) begin
        open_q <= 1'b0;
        age_q  <= '0;
      end else begin
        age_q  <= age_q + CNT_W'(1);
      end
    end
  end

  assign win_open_o = open_q;
endmodule

// File: rtl/sig_row_lookup.sv
module sig_row_lookup
  import sig_row_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [ROW_ENTRIES*8-1:0] ROW_VALUES = {8'hA7, 8'h01, 8'h98, 8'h1E}
) (
  input  logic [ROW_ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0]     byte_o
);
  logic [ROW_ENTRIES-1:0] hit;

  for (genvar i = 0; i < ROW_ENTRIES; i++) begin : g_match
    assign hit[i] = (addr_i == ROW_ADDR[i]);
  end

  always_comb begin
    byte_o = DATA_W'(RSVD_BYTE);
    for (int i = 0; i < ROW_ENTRIES; i++) begin
      if (hit[i]) byte_o = DATA_W'(ROW_VALUES[i*8 +: 8]);
    end
  end
endmodule

// File: rtl/sig_row_rd_ctrl.sv
module sig_row_rd_ctrl
  import sig_row_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned SIG_BIT    = 5,
  parameter int unsigned WIN_CYCLES = 3,
  parameter logic [7:0]  SIG_B1     = 8'h1E,
  parameter logic [7:0]  SIG_B2     = 8'h98,
  parameter logic [7:0]  SIG_B3     = 8'h01,
  parameter logic [7:0]  CAL_B      = 8'hA7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  input  logic                  ld_req_i,
  input  logic [ROW_ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0]     flash_rdata_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  win_open_o
);
  localparam logic [ROW_ENTRIES*8-1:0] ROW_VALUES = {CAL_B, SIG_B3, SIG_B2, SIG_B1};

  logic              win_open;
  logic [DATA_W-1:0] sig_byte;

  sig_row_win_ctl #(
    .DATA_W     (DATA_W),
    .EN_BIT     (EN_BIT),
    .SIG_BIT    (SIG_BIT),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_win_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .ld_req_i    (ld_req_i),
    .win_open_o  (win_open)
  );

  sig_row_lookup #(
    .DATA_W     (DATA_W),
    .ROW_VALUES (ROW_VALUES)
  ) u_lookup (
    .addr_i (ld_addr_i),
    .byte_o (sig_byte)
  );

  assign rd_data_o  = (win_open && ld_req_i) ? sig_byte : flash_rdata_i;
  assign win_open_o = win_open;
endmodule

// File: rtl/sig_row_rd_ctrl_chk.sv
module sig_row_rd_ctrl_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned SIG_BIT    = 5,
  parameter int unsigned WIN_CYCLES = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              ld_req_i,
  input logic [15:0]       ld_addr_i,
  input logic [DATA_W-1:0] flash_rdata_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              win_open_o
);
  localparam int unsigned CW = $clog2(WIN_CYCLES + 2) + 1;

  logic          arm;
  logic          rsvd;
  logic [CW-1:0] open_cnt;

  assign arm  = reg_we_i && reg_wdata_i[EN_BIT] && reg_wdata_i[SIG_BIT];
  assign rsvd = !(ld_addr_i inside {16'h0000, 16'h0001, 16'h0002, 16'h0004});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          open_cnt <= '0;
    else if (arm)         open_cnt <= CW'(1);
    else if (win_open_o)  open_cnt <= open_cnt + CW'(1);
    else                  open_cnt <= '0;
  end

  a_r2_arm_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> win_open_o);

  a_r3_no_spurious_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_open_o && !arm) |=> !win_open_o);

  a_r5_reserved_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open_o && ld_req_i && rsvd) |-> rd_data_o == 8'hFF);

  a_r6_load_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open_o && ld_req_i && !arm) |=> !win_open_o);

  a_r7_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open_o |-> (open_cnt >= CW'(1) && open_cnt <= CW'(WIN_CYCLES)));

  a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !arm) |=> !win_open_o);

  a_r9_flash_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open_o |-> rd_data_o == flash_rdata_i);
endmodule

bind sig_row_rd_ctrl sig_row_rd_ctrl_chk #(
  .DATA_W     (DATA_W),
  .EN_BIT     (EN_BIT),
  .SIG_BIT    (SIG_BIT),
  .WIN_CYCLES (WIN_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .ld_req_i      (ld_req_i),
  .ld_addr_i     (ld_addr_i),
  .flash_rdata_i (flash_rdata_i),
  .rd_data_o     (rd_data_o),
  .win_open_o    (win_open_o)
);

// File: tb/sig_row_rd_ctrl_bench.sv
module sig_row_rd_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] ARM_VAL = 8'h21;
  localparam int NVEC = 7;
  // {address, expected byte}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0000, 8'h1E}, {16'h0002, 8'h98}, {16'h0004, 8'h01}, {16'h0001, 8'hA7},
    {16'h0003, 8'hFF}, {16'h0006, 8'hFF}, {16'h8000, 8'hFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic        ld_req_i = 1'b0;
  logic [15:0] ld_addr_i = '0;
  logic [7:0]  flash_rdata_i = 8'h5A;
  logic [7:0]  rd_data_o;
  logic        win_open_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sig_row_rd_ctrl u_sig_row_rd_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .ld_req_i,
    .ld_addr_i, .flash_rdata_i, .rd_data_o, .win_open_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // leaves the bench at the falling edge of window cycle 1
  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic load_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    ld_req_i = 1'b1; ld_addr_i = a;
    #1;
    chk(req, 16'(rd_data_o), 16'(exp));
    @(negedge clk_i);
    ld_req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    ld_req_i = 1'b1;
    #3;
    chk("R1 win in reset", 16'(win_open_o), 16'h0);
    chk("R1 data in reset", 16'(rd_data_o), 16'h5A);
    ld_req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 win after reset", 16'(win_open_o), 16'h0);

    // R2 R4 R5 R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      flash_rdata_i = 8'(8'h30 + i);
      wr(ARM_VAL);
      chk("R2 armed", 16'(win_open_o), 16'h1);
      load_chk("R4/R5 signature byte", VEC[i][23:8], VEC[i][7:0]);
      chk("R6 closed after load", 16'(win_open_o), 16'h0);
      load_chk("R6 flash after load", VEC[i][23:8], 8'(8'h30 + i));
    end

    // R3 partial writes
    flash_rdata_i = 8'hC3;
    foreach (VEC[k]) if (k < 3) begin
      wr(k == 0 ? 8'h01 : (k == 1 ? 8'h20 : 8'hDE));
      chk("R3 no arm", 16'(win_open_o), 16'h0);
      load_chk("R3 flash data", 16'h0000, 8'hC3);
    end

    // R7 timeout cycles
    wr(ARM_VAL);
    chk("R7 cycle1", 16'(win_open_o), 16'h1);
    @(negedge clk_i);
    chk("R7 cycle2", 16'(win_open_o), 16'h1);
    @(negedge clk_i);
    chk("R7 cycle3", 16'(win_open_o), 16'h1);
    @(negedge clk_i);
    chk("R7 cycle4", 16'(win_open_o), 16'h0);
    // R9 passthrough when closed
    load_chk("R9 flash when closed", 16'h0002, 8'hC3);

    // R7 load in cycle 3 served
    wr(ARM_VAL);
    @(negedge clk_i); @(negedge clk_i);
    load_chk("R7 cycle3 load", 16'h0002, 8'h98);
    // R7 load in cycle 4 gets flash
    wr(ARM_VAL);
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    load_chk("R7 cycle4 load", 16'h0000, 8'hC3);

    // R8 disarm write
    wr(ARM_VAL);
    wr(8'h01);
    chk("R8 disarmed", 16'(win_open_o), 16'h0);
    load_chk("R8 flash after disarm", 16'h0001, 8'hC3);

    // R11 re-arm restarts count
    wr(ARM_VAL);
    @(negedge clk_i);
    wr(ARM_VAL);
    @(negedge clk_i); @(negedge clk_i);
    chk("R11 still open at new cycle3", 16'(win_open_o), 16'h1);
    @(negedge clk_i);
    chk("R11 closed at new cycle4", 16'(win_open_o), 16'h0);

    // R10 async reset in window
    wr(ARM_VAL);
    #2 rst_ni = 1'b0;
    #1;
    chk("R10 reset closes", 16'(win_open_o), 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 stays closed", 16'(win_open_o), 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule